// File: doc/BRIEF.md
# Blanking-Window Horizontal Clock Stretcher

This block drives a bank of horizontal charge-transfer clocks for an image sensor front end. Outside the horizontal blanking window, every output lane repeats its nominal pixel-rate phase one pixel clock later. Inside the window, the lanes can be slowed by an even divisor. A 4-bit width code selects the divisor, and the slowed waveform keeps the phase relation between lanes, so complementary pairs stay opposite.

A width code N of zero leaves the lanes at pixel rate throughout the window. A nonzero N gives a clock of 1/(2N) of the pixel frequency, with each high or low half lasting N pixel periods. The code and the phase pattern are sampled on the first pixel clock of each window. The divide counter restarts at that point, so every line begins its slowed waveform at the same phase. When the window closes, the lanes return to their nominal phase on the next clock.

Top module: `hclk_blank_stretch`

## Requirements
- R1: While the blanking flag is low, each output lane equals that lane's nominal phase input sampled at the previous rising pixel clock edge.
- R2: In a window with a latched nonzero code N, each output lane holds its level for exactly N pixel clocks and then inverts, giving a period of 2N pixel clocks.
- R3: In a window that opened with a code of 0, the outputs follow the nominal phase with one clock of latency, the same as outside the window.
- R4: On the first clock with the flag high, the outputs take the nominal phase sampled at that edge. The divide count restarts from zero, so the first slowed half lasts N clocks.
- R5: While slowed, all lanes invert on the same clock, so each lane keeps its relation (equal or opposite) to every other lane.
- R6: The width code is sampled only at the opening of a window. A change while the window is open has no effect until the next window opens.
- R7: On the first clock after the flag falls, the outputs equal the nominal phase sampled at that edge.
- R8: While reset is asserted (active low, asynchronous), all outputs are 0.
- R9: The largest code, 15, gives halves of 15 clocks and a period of 30 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| blank_i | input | 1 | High while the horizontal blanking window is open |
| width_code_i | input | CODE_W (4) | Stretch code N; 0 keeps pixel rate, N>0 divides by 2N |
| nom_phase_i | input | NUM_CLK (8) | Nominal pixel-rate phase of each horizontal clock lane |
| hclk_o | output | NUM_CLK (8) | Horizontal clock lanes, registered |

## Verification
The nominal phases alternate every cycle between two complementary lane patterns. A stuck or mis-timed pass-through path therefore shows up as a wrong lane value within one clock.

Windows are run with codes 1, 2, 3 and 15. The short codes separate an off-by-one in the half-period count, and code 15 checks the full count width. A code-0 window separates "disabled" from "divide by one".

One window changes the code while it is open, and the next window opens with the new code. This shows whether the code is latched only at the window start. Back-to-back windows with different codes show whether the counter restarts at each window.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

   typedef enum logic [1:0] {
      HBS_PASS  = 2'd0,
      HBS_START = 2'd1,
      HBS_SLOW  = 2'd2
   } hbs_mode_e;

endpackage

// File: rtl/hbs_window_track.sv
module hbs_window_track #(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blank_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              open_o,
   output logic              blank_q_o,
   output logic [CODE_W-1:0] code_act_o
);

   logic              blank_q;
   logic [CODE_W-1:0] code_q;

   assign open_o = blank_i & ~blank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blank_q <= 1'b0;
         code_q  <= '0;
      end else begin
         blank_q <= blank_i;
         if (open_o) code_q <= code_i;
      end
   end

   assign blank_q_o  = blank_q;
   assign code_act_o = code_q;

endmodule

// File: rtl/hbs_divider.sv
module hbs_divider #(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              run_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              half_nxt_o,
   output logic [CODE_W-1:0] cnt_o
);

   localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

   logic [CODE_W-1:0] cnt_q, cnt_d;
   logic              half_q, half_d;
   logic              wrap;

   assign wrap = (cnt_q == (code_i - ONE));

   always_comb begin
      cnt_d  = cnt_q;
      half_d = half_q;
      if (start_i) begin
         cnt_d  = '0;
         half_d = 1'b0;
      end else if (run_i) begin
         if (wrap) begin
            cnt_d  = '0;
            half_d = ~half_q;
         end else begin
            cnt_d = cnt_q + ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         half_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         half_q <= half_d;
      end
   end

   assign half_nxt_o = half_d;
   assign cnt_o      = cnt_q;

endmodule

// File: rtl/hbs_lane.sv
module hbs_lane
   import hbs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  hbs_mode_e mode_i,
   input  logic      nom_i,
   input  logic      ref_i,
   input  logic      half_nxt_i,
   output logic      lane_o
);

   logic lane_d;

   always_comb begin
      unique case (mode_i)
         HBS_SLOW: lane_d = ref_i ^ half_nxt_i;
         default:  lane_d = nom_i;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_o <= 1'b0;
      else        lane_o <= lane_d;
   end

endmodule

// File: rtl/hclk_blank_stretch.sv
module hclk_blank_stretch
   import hbs_pkg::*;
#(
   parameter int NUM_CLK = 8,
   parameter int CODE_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               blank_i,
   input  logic [CODE_W-1:0]  width_code_i,
   input  logic [NUM_CLK-1:0] nom_phase_i,
   output logic [NUM_CLK-1:0] hclk_o
);

   generate
      if (NUM_CLK < 1 || NUM_CLK > 8) begin : g_bad_lanes
         $error("hclk_blank_stretch: NUM_CLK must be 1..8");
      end
      if (CODE_W < 1 || CODE_W > 8) begin : g_bad_code
         $error("hclk_blank_stretch: CODE_W must be 1..8");
      end
   endgenerate

   logic               win_open;
   logic               blank_q;
   logic [CODE_W-1:0]  code_act;
   logic [CODE_W-1:0]  div_cnt;
   logic               half_nxt;
   logic [NUM_CLK-1:0] ref_q;
   hbs_mode_e          mode;

   hbs_window_track #(.CODE_W(CODE_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .blank_i    (blank_i),
      .code_i     (width_code_i),
      .open_o     (win_open),
      .blank_q_o  (blank_q),
      .code_act_o (code_act)
   );

   always_comb begin
      if (!blank_i)            mode = HBS_PASS;
      else if (win_open)       mode = HBS_START;
      else if (code_act == '0) mode = HBS_PASS;
      else                     mode = HBS_SLOW;
   end

   hbs_divider #(.CODE_W(CODE_W)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (mode == HBS_START),
      .run_i      (mode == HBS_SLOW),
      .code_i     (code_act),
      .half_nxt_o (half_nxt),
      .cnt_o      (div_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ref_q <= '0;
      else if (win_open) ref_q <= nom_phase_i;
   end

   generate
      for (genvar gi = 0; gi < NUM_CLK; gi++) begin : g_lane
         hbs_lane u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_i     (mode),
            .nom_i      (nom_phase_i[gi]),
            .ref_i      (ref_q[gi]),
            .half_nxt_i (half_nxt),
            .lane_o     (hclk_o[gi])
         );
      end
   endgenerate

endmodule

// File: rtl/hbs_checker.sv
module hbs_checker #(
   parameter int NUM_CLK = 8,
   parameter int CODE_W  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               blank_i,
   input logic [NUM_CLK-1:0] nom_phase_i,
   input logic [NUM_CLK-1:0] hclk_o,
   input logic               blank_q,
   input logic [CODE_W-1:0]  code_act,
   input logic [CODE_W-1:0]  div_cnt
);

   AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_i |=> (hclk_o == $past(nom_phase_i))); // R1

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_q && code_act != '0) |-> (div_cnt < code_act)); // R2

   AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_i && blank_q && code_act == '0) |=> (hclk_o == $past(nom_phase_i))); // R3

   AST_OPEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_i && !blank_q) |=> (hclk_o == $past(nom_phase_i))); // R4

   AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_i && blank_q && code_act != '0) |=>
      (((hclk_o ^ $past(hclk_o)) == '0) || ((hclk_o ^ $past(hclk_o)) == '1))); // R5

   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_i && blank_q) |=> $stable(code_act)); // R6

   AST_RESET_LOW: assert property (@(posedge clk)
      !rst_n |=> (hclk_o == '0)); // R8

endmodule

bind hclk_blank_stretch hbs_checker #(.NUM_CLK(NUM_CLK), .CODE_W(CODE_W)) u_hbs_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .blank_i     (blank_i),
   .nom_phase_i (nom_phase_i),
   .hclk_o      (hclk_o),
   .blank_q     (blank_q),
   .code_act    (code_act),
   .div_cnt     (div_cnt)
);

// File: tb/hclk_blank_stretch_bench.sv
module hclk_blank_stretch_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NL = 8;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          blank = 1'b0;
   logic [CW-1:0] code = '0;
   logic [NL-1:0] nom = '0;
   logic [NL-1:0] hclk;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit pix = 1'b0;
   int pat = 0;
   string scen = "R8";

   // reference model state
   logic [NL-1:0] exp_q = '0;
   logic [NL-1:0] refp = '0;
   bit            bq = 1'b0;
   int            act = 0;
   int            k = 0;
   string         tag = "R8";

   hclk_blank_stretch #(.NUM_CLK(NL), .CODE_W(CW)) u_hclk_blank_stretch (
      .clk          (clk),
      .rst_n        (rst_n),
      .blank_i      (blank),
      .width_code_i (code),
      .nom_phase_i  (nom),
      .hclk_o       (hclk)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural model: lane = ref ^ ((cycles since open / N) odd)
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q = '0; bq = 1'b0; k = 0; act = 0; tag = "R8";
      end else if (!blank) begin
         exp_q = nom; tag = bq ? "R7" : "R1"; bq = 1'b0;
      end else if (!bq) begin
         act = int'(code); refp = nom; k = 0; exp_q = nom; tag = "R4"; bq = 1'b1;
      end else if (act == 0) begin
         exp_q = nom; tag = "R3";
      end else begin
         k++;
         exp_q = (((k / act) % 2) == 1) ? ~refp : refp;
         tag = "R2";
      end
   end

   task automatic check_now();
      checks++;
      if (hclk !== exp_q) begin
         errors++;
         $display("FAIL %s (%s) cycle %0d: got %h expected %h", tag, scen, cycles, hclk, exp_q);
      end
      if (tag == "R2") begin // R5: all lanes inverted together relative to window-open phase
         checks++;
         if ((hclk ^ refp) !== '0 && (hclk ^ refp) !== '1) begin
            errors++;
            $display("FAIL R5 (%s): got %h expected %h or %h", scen, hclk, refp, ~refp);
         end
      end
   endtask

   task automatic step(input bit b, input logic [CW-1:0] c);
      @(negedge clk);
      check_now();
      pix   = ~pix;
      nom   = (pat == 0) ? (pix ? 8'h55 : 8'hAA) : (pix ? 8'hCC : 8'h33);
      blank = b;
      code  = c;
   endtask

   task automatic line(input int cw, input int len, input int idle);
      for (int i = 0; i < len; i++) step(1'b1, CW'(cw));
      for (int i = 0; i < idle; i++) step(1'b0, CW'(cw));
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         errors++;
         $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      scen = "R8";
      for (int i = 0; i < 3; i++) step(1'b0, '0);   // R8 reset
      rst_n = 1'b1;
      scen = "R1";
      for (int i = 0; i < 6; i++) step(1'b0, '0);   // R1 idle follow
      scen = "R2 N=1"; line(1, 8, 3);              // R2, R7
      scen = "R2 N=2"; line(2, 12, 3);
      pat = 1;
      scen = "R2 N=3"; line(3, 14, 3);
      scen = "R3 N=0"; line(0, 8, 3);               // R3
      scen = "R9 N=15"; line(15, 64, 3);            // R9
      pat = 0;
      scen = "R6 change";                            // R6: code change mid-window
      step(1'b1, CW'(2));
      for (int i = 0; i < 4; i++) step(1'b1, CW'(2));
      for (int i = 0; i < 10; i++) step(1'b1, CW'(5));
      for (int i = 0; i < 3; i++) step(1'b0, CW'(5));
      scen = "R6 next"; line(5, 14, 3);              // new code takes effect now
      scen = "R4 restart"; line(1, 5, 1);            // R4: short gap, counter restart
      line(3, 9, 4);
      @(negedge clk);
      check_now();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule